// File: doc/BRIEF.md
# Azimuthal Event Topology Classifier

This block looks at one event's azimuthal track map and flags whether the event is "open" or "back-to-back". The map has 64 bits, one for each azimuthal wedge, and wedge 63 sits next to wedge 0 on the circle.

The distance between two hit wedges is their circular separation in wedges:
- It is `min(|a-b|, 64-|a-b|)`.
- It runs from 1 to 32.
- One wedge spans 5.625 degrees.

The two flags are decided as follows:
- **Open.** The event is open when any two hit wedges are more than 135 degrees apart, that is, 25 wedges or more.
- **Back-to-back.** The event is back-to-back when some hit wedge has a partner close to its exact opposite. A partner at `(a+32±k) mod 64` counts when `k` is at most the programmable tolerance `t`, which ranges 0..3.

The block also forms the output word. An upstream stage presents each event as one strobe. The strobe carries the map together with the z and r-phi track counts. The block packs the counts and the two flags into one 8-bit trigger word.

The word appears two clock edges after the strobe is sampled. It is then held for three trigger-clock cycles, so downstream logic sees a fixed-width pulse. After that the word returns to zero.

The tolerance lives in a small register inside the block. It is written through a single-cycle write strobe.

Top module: `topo_classifier`

## Requirements
- R1: The open flag is 1 when at least two hit wedges have a circular separation of 25 or more wedges, with separation defined as min(|a-b|, 64-|a-b|).
- R2: The open flag is 0 when every pair of hit wedges is separated by 24 wedges or fewer.
- R3: The back-to-back flag is 1 exactly when two hit wedges a and b satisfy b = (a+32±k) mod 64 for some k ≤ t. Equivalently, their circular separation is at least 32-t.
- R4: The tolerance t is a 2-bit register.
  - Reset sets it to 1.
  - A cycle with `tol_we` high loads `tol_wdata`.
  - An event sampled on the same edge as a write still uses the old value.
- R5: A map with zero or one hit bit produces both flags as 0.
- R6: The trigger word, read from bit 7 down to bit 0, is:
  - bits 7:5 hold the z count;
  - bits 4:3 hold the r-phi count;
  - bit 2 is a spare that is always 0;
  - bit 1 is the open flag;
  - bit 0 is the back-to-back flag.
- R7: An event sampled at clock edge k shows its word after edge k+1. The word stays for exactly 3 cycles and reads zero after edge k+4, unless a newer event replaces it.
- R8: An event arriving while an earlier word is being held replaces that word when it lands, and restarts the 3-cycle window.
- R9: Synchronous active-high reset clears the word to zero and sets the tolerance to 1.
- R10: Separations are computed circularly. A pair that straddles wedge 63/0 is judged by its short way round.
- R11: Map and count inputs have no effect on the word while `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Trigger clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle strobe marking a new event on the inputs below |
| evt_map | input | 64 | Azimuthal hit map, bit i = wedge i |
| evt_zcnt | input | 3 | Z track count passed into the word |
| evt_rcnt | input | 2 | R-phi track count passed into the word |
| tol_we | input | 1 | Tolerance register write strobe |
| tol_wdata | input | 2 | Tolerance value to load |
| trig_word | output | 8 | Held trigger word: counts, spare, open, back-to-back |

## Verification
The hardest situations to reach are those that depend on timing rather than on the map itself:
- a tolerance write landing on the same edge as an event;
- a new event arriving part-way through a held window, so the old word must be cut short and the window restarted.

Directed sequences set up both cases explicitly. These are a write immediately followed by events whose back-to-back result differs between the old and new tolerance, and strobes in adjacent cycles.

A randomized phase then interleaves tolerance writes, sparse maps and variable gaps. A behavioural model compares every cycle, which exercises the separation boundaries at 24/25 and at 32-t on both sides of the wrap.

// File: rtl/topo_pkg.sv
package topo_pkg;

    localparam int NUM_WEDGES   = 64;
    localparam int ZCNT_W       = 3;
    localparam int RCNT_W       = 2;
    localparam int TOL_W        = 2;
    localparam int TOL_DEFAULT  = 1;
    localparam int HOLD_CYCLES  = 3;
    localparam int OPEN_DEG     = 135;

    localparam int HALF_WEDGES  = NUM_WEDGES / 2;
    localparam int IDX_W        = $clog2(NUM_WEDGES);
    localparam int TOL_MAX      = (1 << TOL_W) - 1;
    // smallest wedge separation whose angle strictly exceeds OPEN_DEG
    localparam int OPEN_MIN_SEP = (OPEN_DEG * NUM_WEDGES) / 360 + 1;
    localparam int WORD_W       = ZCNT_W + RCNT_W + 3;

    typedef logic [NUM_WEDGES-1:0] wedge_map_t;
    typedef logic [IDX_W-1:0]      wedge_idx_t;
    typedef logic [TOL_W-1:0]      tol_t;

    typedef struct packed {
        logic [ZCNT_W-1:0] zcnt;
        logic [RCNT_W-1:0] rcnt;
        logic              spare;
        logic              open_f;
        logic              b2b_f;
    } trig_word_t;

    typedef struct packed {
        logic              valid;
        logic [ZCNT_W-1:0] zcnt;
        logic [RCNT_W-1:0] rcnt;
        wedge_map_t        open_hits;
        wedge_map_t        b2b_hits;
    } pair_stage_t;

    function automatic wedge_idx_t wrap_idx(input int i);
        int r;
        r = ((i % NUM_WEDGES) + NUM_WEDGES) % NUM_WEDGES;
        return wedge_idx_t'(r);
    endfunction

endpackage

// File: rtl/topo_tol_reg.sv
module topo_tol_reg
    import topo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  tol_t wdata,
    output tol_t tol
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tol <= tol_t'(TOL_DEFAULT);
        end else if (we) begin
            tol <= wdata;
        end
    end

    // R4: a write lands on the next cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (tol == $past(wdata)));

    // R9: tolerance comes out of reset at its default
    a_r9_reset_default: assert property (@(posedge clk)
        $past(rst) |-> (tol == tol_t'(TOL_DEFAULT)));

endmodule

// File: rtl/topo_pair_stage.sv
module topo_pair_stage
    import topo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  wedge_map_t           in_map,
    input  logic [ZCNT_W-1:0]    in_zcnt,
    input  logic [RCNT_W-1:0]    in_rcnt,
    input  tol_t                 tol,
    output pair_stage_t          stage_q
);

    wedge_map_t open_raw;
    wedge_map_t b2b_raw;

    // Each wedge looks forward only: every qualifying pair is seen from
    // the endpoint whose forward distance lies in [OPEN_MIN_SEP, HALF].
    for (genvar a = 0; a < NUM_WEDGES; a++) begin : g_wedge
        logic far_any;
        logic opp_any;

        always_comb begin
            far_any = 1'b0;
            for (int d = OPEN_MIN_SEP; d <= HALF_WEDGES; d++) begin
                far_any = far_any | in_map[wrap_idx(a + d)];
            end
        end

        always_comb begin
            opp_any = in_map[wrap_idx(a + HALF_WEDGES)];
            for (int k = 1; k <= TOL_MAX; k++) begin
                if (k <= int'(tol)) begin
                    opp_any = opp_any
                            | in_map[wrap_idx(a + HALF_WEDGES + k)]
                            | in_map[wrap_idx(a + HALF_WEDGES - k)];
                end
            end
        end

        assign open_raw[a] = in_map[a] & far_any;
        assign b2b_raw[a]  = in_map[a] & opp_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= in_valid;
            if (in_valid) begin
                stage_q.zcnt      <= in_zcnt;
                stage_q.rcnt      <= in_rcnt;
                stage_q.open_hits <= open_raw;
                stage_q.b2b_hits  <= b2b_raw;
            end
        end
    end

    // R5: fewer than two hits can never leave a pair bit set
    a_r5_sparse_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ($countones(in_map) < 2)) |=>
            ((stage_q.open_hits == '0) && (stage_q.b2b_hits == '0)));

    // R11: stage contents only move on a strobe
    a_r11_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(stage_q.open_hits) && $stable(stage_q.b2b_hits)));

endmodule

// File: rtl/topo_out_hold.sv
module topo_out_hold
    import topo_pkg::*;
#(
    parameter int HOLD = HOLD_CYCLES
) (
    input  logic         clk,
    input  logic         rst,
    input  pair_stage_t  stage_i,
    output trig_word_t   word_q
);

    localparam int CNT_W = $clog2(HOLD + 1);

    trig_word_t       word_next;
    logic [CNT_W-1:0] hold_q;

    always_comb begin
        word_next.zcnt   = stage_i.zcnt;
        word_next.rcnt   = stage_i.rcnt;
        word_next.spare  = 1'b0;
        word_next.open_f = |stage_i.open_hits;
        word_next.b2b_f  = |stage_i.b2b_hits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            hold_q <= '0;
        end else if (stage_i.valid) begin
            word_q <= word_next;
            hold_q <= CNT_W'(HOLD - 1);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end else begin
            word_q <= '0;
        end
    end

    // R7: without a load the word either stays or drops to zero
    a_r7_no_spurious_change: assert property (@(posedge clk) disable iff (rst)
        !stage_i.valid |=> ((word_q == $past(word_q)) || (word_q == '0)));

    // R7: an exhausted window with no new load clears the word
    a_r7_window_ends: assert property (@(posedge clk) disable iff (rst)
        ((hold_q == '0) && !stage_i.valid) |=> (word_q == '0));

    // R8: a load always restarts the full window
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        stage_i.valid |=> (hold_q == CNT_W'(HOLD - 1)));

endmodule

// File: rtl/topo_classifier.sv
module topo_classifier
    import topo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_valid,
    input  logic [63:0] evt_map,
    input  logic [2:0]  evt_zcnt,
    input  logic [1:0]  evt_rcnt,
    input  logic        tol_we,
    input  logic [1:0]  tol_wdata,
    output logic [7:0]  trig_word
);

    tol_t        tol_cur;
    pair_stage_t stage;
    trig_word_t  word;

    topo_tol_reg u_tol (
        .clk   (clk),
        .rst   (rst),
        .we    (tol_we),
        .wdata (tol_wdata),
        .tol   (tol_cur)
    );

    topo_pair_stage u_pair (
        .clk      (clk),
        .rst      (rst),
        .in_valid (evt_valid),
        .in_map   (evt_map),
        .in_zcnt  (evt_zcnt),
        .in_rcnt  (evt_rcnt),
        .tol      (tol_cur),
        .stage_q  (stage)
    );

    topo_out_hold #(.HOLD(HOLD_CYCLES)) u_out (
        .clk     (clk),
        .rst     (rst),
        .stage_i (stage),
        .word_q  (word)
    );

    assign trig_word = word;

    // R6: the spare position never carries a one at the port
    a_r6_spare_low: assert property (@(posedge clk) disable iff (rst)
        stage.valid |=> (trig_word[2] == 1'b0));

    // R9: reset leaves the output word cleared
    a_r9_word_cleared: assert property (@(posedge clk)
        $past(rst) |-> (trig_word == 8'h00));

endmodule

// File: tb/topo_classifier_tb_top.sv
module topo_classifier_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [63:0] evt_map;
    logic [2:0]  evt_zcnt;
    logic [1:0]  evt_rcnt;
    logic        tol_we;
    logic [1:0]  tol_wdata;
    logic [7:0]  trig_word;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    chk_on   = 1'b0;
    bit    finished = 1'b0;
    string cur_tag  = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    topo_classifier dut_i (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_map   (evt_map),
        .evt_zcnt  (evt_zcnt),
        .evt_rcnt  (evt_rcnt),
        .tol_we    (tol_we),
        .tol_wdata (tol_wdata),
        .trig_word (trig_word)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] ref_word(input logic [63:0] m, input logic [2:0] z,
                                            input logic [1:0] r, input logic [1:0] t);
        bit op = 0;
        bit bb = 0;
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                int d;
                int s;
                if (i != j && m[i] && m[j]) begin
                    d = (i > j) ? i - j : j - i;
                    s = (d > 32) ? 64 - d : d;
                    if (s > 24) op = 1;
                    if (s >= 32 - int'(t)) bb = 1;
                end
            end
        end
        return {z, r, 1'b0, op, bb};
    endfunction

    logic [7:0] exp_word;
    logic [7:0] pend_word;
    bit         pend_v;
    int         hold;
    logic [1:0] m_tol;

    always @(posedge clk) begin
        if (rst) begin
            exp_word = 8'h00;
            pend_v   = 0;
            hold     = 0;
            m_tol    = 2'd1;
        end else begin
            if (pend_v) begin
                exp_word = pend_word;
                hold     = 2;
            end else if (hold > 0) begin
                hold = hold - 1;
            end else begin
                exp_word = 8'h00;
            end
            pend_v = evt_valid;
            if (evt_valid) pend_word = ref_word(evt_map, evt_zcnt, evt_rcnt, m_tol);
            if (tol_we) m_tol = tol_wdata;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            n_checks++;
            if (trig_word !== exp_word) begin
                n_fail++;
                $display("FAIL %s: trig_word=%h expected %h at %0t", cur_tag, trig_word, exp_word, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic [63:0] m, input logic [2:0] z, input logic [1:0] r);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_map   = m;
        evt_zcnt  = z;
        evt_rcnt  = r;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        evt_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] m, input logic [2:0] z, input logic [1:0] r);
        drive(m, z, r);
        idle(6);
    endtask

    task automatic wr_tol(input logic [1:0] v);
        @(negedge clk);
        tol_we    = 1'b1;
        tol_wdata = v;
        @(negedge clk);
        tol_we    = 1'b0;
    endtask

    function automatic logic [63:0] two(input int a, input int b);
        logic [63:0] m = '0;
        m[a] = 1'b1;
        m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] sparse();
        return {$urandom, $urandom} & {$urandom, $urandom}
             & {$urandom, $urandom} & {$urandom, $urandom};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        rst       = 1'b1;
        evt_valid = 1'b0;
        evt_map   = '0;
        evt_zcnt  = '0;
        evt_rcnt  = '0;
        tol_we    = 1'b0;
        tol_wdata = '0;
        @(posedge clk);
        chk_on = 1'b1;            // R9 checked while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(3);

        cur_tag = "R5";
        send('0, 3'd5, 2'd2);
        send(64'h1 << 5, 3'd5, 2'd2);
        send(64'h1 << 63, 3'd1, 2'd1);

        cur_tag = "R1";
        send(two(0, 25), 3'd1, 2'd0);
        send(two(10, 42), 3'd2, 2'd1);
        send(two(7, 33), 3'd0, 2'd0);

        cur_tag = "R2";
        send(two(0, 24), 3'd1, 2'd1);
        send(two(40, 16), 3'd3, 2'd0);
        send(64'h0000_0000_00FF_FFFF, 3'd0, 2'd0);

        cur_tag = "R10";
        send(two(60, 22), 3'd1, 2'd0);
        send(two(62, 20), 3'd1, 2'd0);
        send(two(63, 31), 3'd1, 2'd0);

        cur_tag = "R4";           // default t = 1
        send(two(3, 36), 3'd0, 2'd0);
        send(two(3, 37), 3'd0, 2'd0);

        cur_tag = "R3";
        wr_tol(2'd2);
        send(two(3, 37), 3'd0, 2'd0);
        send(two(3, 38), 3'd0, 2'd0);
        wr_tol(2'd0);
        send(two(3, 35), 3'd0, 2'd0);
        send(two(3, 36), 3'd0, 2'd0);
        wr_tol(2'd3);
        send(two(3, 38), 3'd0, 2'd0);
        send(two(61, 26), 3'd0, 2'd0);

        cur_tag = "R4";           // write and event on the same edge
        @(negedge clk);
        tol_we = 1'b1; tol_wdata = 2'd0;
        evt_valid = 1'b1; evt_map = two(3, 37); evt_zcnt = 3'd4; evt_rcnt = 2'd1;
        @(negedge clk);
        tol_we = 1'b0;
        evt_map = two(3, 37);
        idle(6);
        wr_tol(2'd1);

        cur_tag = "R6";
        send(two(10, 42), 3'd7, 2'd3);
        send(two(0, 1), 3'd6, 2'd2);

        cur_tag = "R7";
        send(two(5, 40), 3'd2, 2'd1);

        cur_tag = "R8";
        drive(two(0, 32), 3'd1, 2'd1);
        drive(two(0, 5), 3'd2, 2'd2);
        idle(2);
        drive(two(8, 40), 3'd3, 2'd3);
        idle(8);

        cur_tag = "R11";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            evt_valid = 1'b0;
            evt_map   = {$urandom, $urandom};
            evt_zcnt  = 3'($urandom);
            evt_rcnt  = 2'($urandom);
        end
        send(two(2, 30), 3'd1, 2'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            evt_map = two(0, 32);
            evt_zcnt = 3'd7;
        end
        idle(4);

        cur_tag = "R1";
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 10) == 0) wr_tol(2'($urandom));
            if (($urandom % 3) == 0) drive(two(int'($urandom % 64), int'($urandom % 64)),
                                           3'($urandom), 2'($urandom));
            else drive(sparse(), 3'($urandom), 2'($urandom));
            idle(1 + int'($urandom % 5));
        end
        idle(6);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule